// File: doc/BRIEF.md
# Veto Input Time-In Aligner

This block sits inside a veto unit and lines up several serial veto lines onto one bunch timeline. Each detector raises its veto line in step with the bunch it rejects, but cable and processing lengths differ between detectors. The aligner measures each line's lag behind a common reference and then delays every early line in whole clock steps (10 ns at 100 MHz) until all lines agree with the latest one. One shared bunch counter, cleared by the train-start or test-veto reference and advanced by the 5 MHz bunch strobe, tags each aligned veto with a 12-bit bunch number. The bunch number carried on the veto lines is never decoded.

Calibration is run by raising `cal_en` and pulsing `ref_pulse` while every detector sends a veto on bunch 0. Each line's counter stops on that line's first rising edge. When every line has reported or timed out, the per-line delays are loaded and `cal_done` rises. Normal operation resumes once `cal_en` is lowered.

Top module: `veto_timein_aligner`

## Requirements
- R1: Every veto line passes a two-register synchroniser. With a delay d in effect on a line, a rise on that line gives `veto_valid` high from the (3+d)-th rising clock edge after the line changes. All delays are 0 after reset.
- R2: The bunch counter is 12 bits wide. It clears to 0 on a cycle with `ref_pulse` high, adds 1 on a cycle with `bunch_stb` high, lets the clear win when both are high, and wraps from 4095 to 0.
- R3: `veto_valid` is a one-cycle pulse raised when the OR of the aligned, enabled lines goes from 0 to 1. `veto_bid` carries the bunch count of that cycle and holds it until the next pulse.
- R4: A calibration starts when `ref_pulse` is sampled high while `cal_en` is high. Each line's lag counter then runs from 0 and stops at the first rising edge of that line's synchronised copy.
- R5: When calibration ends, each enabled line's delay equals the largest lag measured among enabled lines minus its own lag. `tap_dly` bits [8i+7:8i] carry the delay of line i.
- R6: A line whose counter reaches 255 with no rising edge sets `cal_timeout` bit i, gets delay 0, and is ignored by the veto output until the next calibration.
- R7: `cal_done` rises once every line has stopped or timed out, stays high, and is 0 in the cycle after a new calibration start.
- R8: While `cal_en` is high, `veto_valid` stays low.
- R9: After calibration, vetoes for one bunch that reach the lines with their measured lags come out as exactly one `veto_valid` pulse, 3 cycles after the latest line rose.
- R10: After reset, `veto_valid`, `veto_bid`, `cal_done`, `cal_timeout` and `tap_dly` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cal_en | input | 1 | Calibration mode; blocks the veto output |
| ref_pulse | input | 1 | Train-start or test-veto reference, one cycle |
| bunch_stb | input | 1 | Bunch clock strobe, one cycle per bunch |
| veto_in | input | N_IN | Raw veto lines |
| veto_valid | output | 1 | One-cycle aligned veto pulse |
| veto_bid | output | BID_W | Bunch number of the last veto pulse |
| cal_done | output | 1 | Calibration finished and delays loaded |
| cal_timeout | output | N_IN | Line i saw no edge during calibration |
| tap_dly | output | N_IN*LAG_W | Applied delay per line, 8 bits each |

## Verification
The assertions take `ref_pulse` to be a single-cycle pulse, and `cal_en` and `bunch_stb` to be synchronous to the clock. The stimulus drives every input at the falling edge and never holds the reference high for two cycles. The checks also rely on each veto line staying low before its calibration edge and low again long enough for the delay line to empty before the next test. The bench waits more than the full delay depth after every firing, so no old level is still inside a shift register when the next rise is measured.

// File: rtl/veto_align_pkg.sv
// Shared definitions for the veto time-in aligner.
// Assumes: all users run in the single 100 MHz clock domain.
package veto_align_pkg;
    typedef enum logic {
        CAL_IDLE = 1'b0,
        CAL_RUN  = 1'b1
    } cal_state_e;

    localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/veto_in_sync.sv
// Multi-stage synchroniser for a vector of veto lines.
// Assumes: every bit is independent; equal latency across bits is what keeps
// measured lags comparable.
module veto_in_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage [STAGES];

    // Shift each line through the register chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stage[k] <= '0;
        end else begin
            stage[0] <= din;
            for (int k = 1; k < STAGES; k++) stage[k] <= stage[k-1];
        end
    end

    assign dout = stage[STAGES-1];
endmodule

// File: rtl/veto_lag_meter.sv
// Measures the cycles from a start strobe to the first rising edge of one line.
// Assumes: start is a single-cycle strobe; a rise in the start cycle is ignored.
module veto_lag_meter #(
    parameter int LAG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             sig,
    output logic [LAG_W-1:0] lag,
    output logic             done,
    output logic             timed_out
);
    logic running;
    logic sig_q;
    logic rise;

    assign rise = sig & ~sig_q;

    // Remember the previous line level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig;
    end

    // Count until the first edge or until the counter saturates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lag       <= '0;
            running   <= 1'b0;
            done      <= 1'b0;
            timed_out <= 1'b0;
        end else if (start) begin
            lag       <= '0;
            running   <= 1'b1;
            done      <= 1'b0;
            timed_out <= 1'b0;
        end else if (running) begin
            if (rise) begin
                running <= 1'b0;
                done    <= 1'b1;
            end else if (lag == '1) begin
                running   <= 1'b0;
                done      <= 1'b1;
                timed_out <= 1'b1;
            end else begin
                lag <= lag + 1'b1;
            end
        end
    end
endmodule

// File: rtl/veto_delay_tap.sv
// Programmable delay of one line by 0..DEPTH clock cycles.
// Assumes: sel never exceeds DEPTH; sel of 0 passes the input straight through.
module veto_delay_tap #(
    parameter int DEPTH = 255,
    parameter int SEL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    input  logic [SEL_W-1:0] sel,
    output logic             dout
);
    logic [DEPTH-1:0] sr;

    // Shift the line one stage per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) sr <= '0;
        else        sr <= {sr[DEPTH-2:0], din};
    end

    // Pick the tap for the programmed delay.
    always_comb begin
        if (sel == '0) dout = din;
        else           dout = sr[sel - 1'b1];
    end
endmodule

// File: rtl/veto_bunch_counter.sv
// Shared bunch number counter.
// Assumes: clear and step are single-cycle strobes in this clock domain.
module veto_bunch_counter #(
    parameter int BID_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    output logic [BID_W-1:0] count
);
    // Clear wins over step; the count wraps naturally.
    always_ff @(posedge clk) begin
        if (!rst_n)     count <= '0;
        else if (clear) count <= '0;
        else if (step)  count <= count + 1'b1;
    end
endmodule

// File: rtl/veto_timein_aligner.sv
// Veto input time-in aligner: measures each line's lag to a reference,
// delays early lines to match the latest, and tags aligned vetoes with a
// shared bunch number.
// Assumes: ref_pulse is one cycle wide; all inputs are synchronous except
// veto_in, which is synchronised here.
module veto_timein_aligner
    import veto_align_pkg::*;
#(
    parameter int N_IN   = 4,
    parameter int LAG_W  = 8,
    parameter int BID_W  = 12,
    parameter int SYNC_N = SYNC_STAGES
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cal_en,
    input  logic                    ref_pulse,
    input  logic                    bunch_stb,
    input  logic [N_IN-1:0]         veto_in,
    output logic                    veto_valid,
    output logic [BID_W-1:0]        veto_bid,
    output logic                    cal_done,
    output logic [N_IN-1:0]         cal_timeout,
    output logic [N_IN*LAG_W-1:0]   tap_dly
);
    localparam int DLY_DEPTH = (1 << LAG_W) - 1;

    logic [N_IN-1:0]  veto_sync;
    logic [LAG_W-1:0] lag      [N_IN];
    logic [LAG_W-1:0] dly_q    [N_IN];
    logic [N_IN-1:0]  lag_done;
    logic [N_IN-1:0]  lag_tmo;
    logic [N_IN-1:0]  use_q;
    logic [N_IN-1:0]  tap_out;
    logic [N_IN-1:0]  aligned;
    logic [LAG_W-1:0] lag_max;
    logic [BID_W-1:0] bunch_q;
    logic             cal_start;
    logic             any_now;
    logic             any_q;
    cal_state_e       cal_state;

    assign cal_start   = cal_en & ref_pulse;
    assign cal_timeout = lag_tmo;

    veto_in_sync #(.W(N_IN), .STAGES(SYNC_N)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (veto_in),
        .dout (veto_sync)
    );

    veto_bunch_counter #(.BID_W(BID_W)) u_bunch (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(ref_pulse),
        .step (bunch_stb),
        .count(bunch_q)
    );

    for (genvar g = 0; g < N_IN; g++) begin : g_lane
        veto_lag_meter #(.LAG_W(LAG_W)) u_meter (
            .clk      (clk),
            .rst_n    (rst_n),
            .start    (cal_start),
            .sig      (veto_sync[g]),
            .lag      (lag[g]),
            .done     (lag_done[g]),
            .timed_out(lag_tmo[g])
        );

        veto_delay_tap #(.DEPTH(DLY_DEPTH), .SEL_W(LAG_W)) u_tap (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (veto_sync[g]),
            .sel  (dly_q[g]),
            .dout (tap_out[g])
        );

        assign aligned[g]                   = tap_out[g] & use_q[g];
        assign tap_dly[g*LAG_W +: LAG_W]    = dly_q[g];
    end

    // Largest lag among lines that reported an edge.
    always_comb begin
        lag_max = '0;
        for (int i = 0; i < N_IN; i++) begin
            if (!lag_tmo[i] && (lag[i] > lag_max)) lag_max = lag[i];
        end
    end

    // Calibration sequencing and loading of the per-line delays.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cal_state <= CAL_IDLE;
            cal_done  <= 1'b0;
            use_q     <= '1;
            for (int i = 0; i < N_IN; i++) dly_q[i] <= '0;
        end else if (cal_start) begin
            cal_state <= CAL_RUN;
            cal_done  <= 1'b0;
        end else if ((cal_state == CAL_RUN) && (&lag_done)) begin
            cal_state <= CAL_IDLE;
            cal_done  <= 1'b1;
            use_q     <= ~lag_tmo;
            for (int i = 0; i < N_IN; i++) begin
                dly_q[i] <= lag_tmo[i] ? '0 : (lag_max - lag[i]);
            end
        end
    end

    assign any_now = |aligned;

    // Edge-detect the merged aligned vetoes and tag them with the bunch number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            any_q      <= 1'b0;
            veto_valid <= 1'b0;
            veto_bid   <= '0;
        end else begin
            any_q      <= any_now;
            veto_valid <= !cal_en && any_now && !any_q;
            if (!cal_en && any_now && !any_q) veto_bid <= bunch_q;
        end
    end
endmodule

// File: rtl/veto_align_chk.sv
// Property checker for the veto time-in aligner, bound to the top module.
// Assumes: it observes the top's ports plus the shared bunch counter.
module veto_align_chk #(
    parameter int N_IN  = 4,
    parameter int LAG_W = 8,
    parameter int BID_W = 12
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cal_en,
    input logic                  ref_pulse,
    input logic                  bunch_stb,
    input logic                  veto_valid,
    input logic                  cal_done,
    input logic [N_IN-1:0]       cal_timeout,
    input logic [N_IN*LAG_W-1:0] tap_dly,
    input logic [BID_W-1:0]      bunch_q
);
    // Input assumption: the reference is a single-cycle pulse (R2, R4).
    assert_ref_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pulse |=> !ref_pulse);

    assert_pulse_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        veto_valid |=> !veto_valid);

    assert_quiet_in_cal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cal_en |=> !veto_valid);

    assert_bunch_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pulse |=> (bunch_q == '0));

    assert_bunch_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_pulse && bunch_stb) |=> (bunch_q == BID_W'($past(bunch_q) + 1'b1)));

    assert_bunch_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_pulse && !bunch_stb) |=> $stable(bunch_q));

    assert_restart_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_en && ref_pulse) |=> !cal_done);

    for (genvar g = 0; g < N_IN; g++) begin : g_tmo
        assert_timeout_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (cal_done && cal_timeout[g]) |-> (tap_dly[g*LAG_W +: LAG_W] == '0));
    end
endmodule

bind veto_timein_aligner veto_align_chk #(
    .N_IN (N_IN),
    .LAG_W(LAG_W),
    .BID_W(BID_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cal_en     (cal_en),
    .ref_pulse  (ref_pulse),
    .bunch_stb  (bunch_stb),
    .veto_valid (veto_valid),
    .cal_done   (cal_done),
    .cal_timeout(cal_timeout),
    .tap_dly    (tap_dly),
    .bunch_q    (bunch_q)
);

// File: tb/sim_veto_timein_aligner.sv
module sim_veto_timein_aligner;
    localparam int CLK_PERIOD = 10;
    localparam int N_IN       = 4;
    localparam int WDOG       = 150000;
    localparam int NVEC       = 6;

    // Vector: [67:36] lags (8 bits per line, FF = line never rises),
    //         [35:4] expected delays, [3:0] expected timeout bits.
    localparam logic [67:0] VEC [NVEC] = '{
        {32'h281E140A, 32'h000A141E, 4'h0},
        {32'h32323232, 32'h00000000, 4'h0},
        {32'h013C7805, 32'h773C0073, 4'h0},
        {32'hFF0AFF1E, 32'h00140000, 4'hA},
        {32'hFFFFFFFF, 32'h00000000, 4'hF},
        {32'h034D0264, 32'h61176200, 4'h0}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cal_en = 1'b0;
    logic             ref_pulse = 1'b0;
    logic             bunch_stb = 1'b0;
    logic [N_IN-1:0]  veto_in = '0;
    logic             veto_valid;
    logic [11:0]      veto_bid;
    logic             cal_done;
    logic [N_IN-1:0]  cal_timeout;
    logic [31:0]      tap_dly;
    int               n_cmp = 0;
    int               n_bad = 0;
    bit               finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    veto_timein_aligner u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .cal_en     (cal_en),
        .ref_pulse  (ref_pulse),
        .bunch_stb  (bunch_stb),
        .veto_in    (veto_in),
        .veto_valid (veto_valid),
        .veto_bid   (veto_bid),
        .cal_done   (cal_done),
        .cal_timeout(cal_timeout),
        .tap_dly    (tap_dly)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive lines at their lag cycle and record output pulses.
    task automatic run_window(input logic [31:0] lags, input logic [3:0] en, input int win,
                              output int first, output int np);
        first = -1;
        np    = 0;
        for (int c = 0; c < win; c++) begin
            @(negedge clk);
            if (veto_valid) begin
                np++;
                if (first < 0) first = c;
            end
            for (int i = 0; i < N_IN; i++)
                if (en[i] && (lags[i*8 +: 8] == 8'(c))) veto_in[i] = 1'b1;
        end
        @(negedge clk);
        veto_in = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int first;
        int np;
        idle(4);
        rst_n = 1'b1;
        idle(1);
        // R10 reset state
        chk("R10 valid", 64'(veto_valid), 64'd0);
        chk("R10 bid", 64'(veto_bid), 64'd0);
        chk("R10 done", 64'(cal_done), 64'd0);
        chk("R10 timeout", 64'(cal_timeout), 64'd0);
        chk("R10 delays", 64'(tap_dly), 64'd0);

        // R2/R3: count five strobes after a reference, then fire line 0
        ref_pulse = 1'b1; idle(1); ref_pulse = 1'b0;
        for (int s = 0; s < 5; s++) begin
            bunch_stb = 1'b1; idle(1); bunch_stb = 1'b0; idle(1);
        end
        run_window(32'h0, 4'b0001, 12, first, np);
        chk("R1 latency d=0", 64'(first), 64'd3);
        chk("R3 single pulse", 64'(np), 64'd1);
        chk("R2 bid after 5", 64'(veto_bid), 64'd5);
        idle(10);

        // R2: clear wins over step
        ref_pulse = 1'b1; bunch_stb = 1'b1; idle(1); ref_pulse = 1'b0; bunch_stb = 1'b0;
        run_window(32'h0, 4'b0100, 12, first, np);
        chk("R2 clear wins", 64'(veto_bid), 64'd0);
        idle(10);

        // R2: wrap after 4097 steps
        ref_pulse = 1'b1; idle(1); ref_pulse = 1'b0;
        bunch_stb = 1'b1; idle(4097); bunch_stb = 1'b0;
        run_window(32'h0, 4'b0010, 12, first, np);
        chk("R2 wrap", 64'(veto_bid), 64'd1);
        idle(10);

        // R3: two lines rising together give one pulse
        run_window(32'h0, 4'b1010, 12, first, np);
        chk("R3 merged count", 64'(np), 64'd1);
        chk("R3 merged latency", 64'(first), 64'd3);
        idle(10);

        // Calibration vectors
        for (int v = 0; v < NVEC; v++) begin
            automatic logic [31:0] lags = VEC[v][67:36];
            automatic logic [31:0] edly = VEC[v][35:4];
            automatic logic [3:0]  eto  = VEC[v][3:0];
            automatic int          maxl = 0;
            for (int i = 0; i < N_IN; i++)
                if (!eto[i] && int'(lags[i*8 +: 8]) > maxl) maxl = int'(lags[i*8 +: 8]);

            cal_en = 1'b1; idle(3);
            ref_pulse = 1'b1; idle(1); ref_pulse = 1'b0;
            chk("R7 done cleared at start", 64'(cal_done), 64'd0);
            run_window(lags, ~eto, 300, first, np);
            chk("R8 no pulse in cal", 64'(np), 64'd0);
            chk("R7 done", 64'(cal_done), 64'd1);
            chk("R5 delays", 64'(tap_dly), 64'(edly));
            chk("R6 timeout bits", 64'(cal_timeout), 64'(eto));
            idle(260);
            cal_en = 1'b0; idle(3);

            // R9 alignment of one bunch across all live lines
            run_window(lags, ~eto, maxl + 40, first, np);
            if (eto != 4'hF) begin
                chk("R9 aligned count", 64'(np), 64'd1);
                chk("R9 aligned latency", 64'(first), 64'(maxl + 3));
            end else begin
                chk("R6 all masked", 64'(np), 64'd0);
            end
            idle(260);

            // R1/R6 per-line latency through its tap
            for (int i = 0; i < N_IN; i++) begin
                run_window(32'h0, 4'(1 << i), 280, first, np);
                if (eto[i]) begin
                    chk("R6 masked line", 64'(np), 64'd0);
                end else begin
                    chk("R1 tap count", 64'(np), 64'd1);
                    chk("R1 tap latency", 64'(first), 64'(3 + int'(edly[i*8 +: 8])));
                end
                idle(260);
            end
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule